// File: doc/BRIEF.md
# Dot-Clock Panel Timing Generator

This block produces the line and frame timing for a parallel RGB panel that is clocked one pixel per cycle. A horizontal counter walks through each line and a vertical counter walks through each frame. From these counters the block derives a horizontal sync pulse, a vertical sync pulse, a data-enable signal and a pixel-request strobe. The strobe comes with the pixel's column and row inside the visible area. Configuration arrives on plain input buses that a register file elsewhere keeps stable while the generator is stopped.

Both wait counts are measured from the first clock of the sync pulse, so each one includes the pulse width. The frame base address that a fetch engine should read from is double buffered. Software may present a new address at any time, and the generator copies it into the current address only in the cycle in which a frame begins. When the run request is withdrawn, the generator finishes the frame in progress and only then reports itself idle.

Top module: `dotclk_timing_gen`

## Requirements
- R1: After reset, `busy` and `pix_req` are 0, `xpos`, `ypos` and `cur_base` are 0, and `hsync`, `vsync` and `de` sit at their inactive levels.
- R2: When `run_req` is high while the block is idle, `busy` is 1 one cycle later. The counters then stand at pixel 0 of line 0, with horizontal and vertical sync both active.
- R3: A line lasts `line_period` clocks. Horizontal sync is active for the first `hsync_width` clocks of every line.
- R4: A frame lasts `frame_lines` lines. Vertical sync starts at the first clock of the frame and lasts `vsync_width` lines when `vsync_unit_lines` is 1, or `vsync_width` clocks when it is 0.
- R5: `pix_req` is 1 exactly when the pixel index lies in [`h_wait`, `h_wait`+`h_active`) and the line index lies in [`v_wait`, `v_wait`+`v_active`). Both indices count from 0 at the start of their sync pulse.
- R6: Inside its window, `xpos` equals pixel index minus `h_wait` and `ypos` equals line index minus `v_wait`. Outside its window each output holds the value it last had.
- R7: When a polarity input (`hs_high`, `vs_high`, `de_high`) is 1, its output is high while active and low otherwise. When it is 0, the levels are inverted. `de` does not depend on `sync_en`.
- R8: While `sync_en` is 0, `hsync` and `vsync` stay at their inactive levels, and the counters and `pix_req` run as usual.
- R9: `cur_base` takes the value of `next_base` only in the cycle that starts a frame, meaning a start from idle or a wrap into a new frame with `run_req` high. At all other times it holds its value.
- R10: After `run_req` falls, `busy` stays 1 until the last pixel of the last line of the current frame. It is 0 from the next cycle on, and after that every output is inactive.
- R11: `sample_falling` follows `fall_edge`, which tells the pad logic to launch pixel data on the falling dot-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Run request; a fall takes effect at the end of the frame |
| sync_en | input | 1 | Lets the sync outputs become active |
| vsync_unit_lines | input | 1 | 1: vsync width counted in lines; 0: counted in clocks |
| line_period | input | HW (18) | Clocks per line |
| hsync_width | input | HSW_W (14) | Horizontal sync width in clocks |
| h_wait | input | HWAIT_W (12) | First visible pixel index, counted from the start of hsync |
| h_active | input | HW (18) | Visible pixels per line |
| frame_lines | input | VW (16) | Lines per frame |
| vsync_width | input | VSW_W (18) | Vertical sync width |
| v_wait | input | VW (16) | First visible line index, counted from the start of vsync |
| v_active | input | VW (16) | Visible lines per frame |
| hs_high | input | 1 | Horizontal sync is active high |
| vs_high | input | 1 | Vertical sync is active high |
| de_high | input | 1 | Data enable is active high |
| fall_edge | input | 1 | Select falling-edge data launch |
| next_base | input | AW (32) | Frame base address for the next frame |
| hsync | output | 1 | Horizontal sync pin level |
| vsync | output | 1 | Vertical sync pin level |
| de | output | 1 | Data enable pin level |
| pix_req | output | 1 | Pixel request strobe, active high |
| xpos | output | HW (18) | Column within the visible area |
| ypos | output | VW (16) | Row within the visible area |
| cur_base | output | AW (32) | Base address of the frame in progress |
| busy | output | 1 | Generator running, including the drain after a stop |
| sample_falling | output | 1 | Data launch edge select for the pad logic |

## Verification
Two pairs of events can land on the same clock. The end of a frame can coincide with a stop request, and it can also coincide with a change of `next_base`. The bench waits until its reference model stands on the last pixel of the last line. In that cycle it either keeps `run_req` high and presents a new address, which must appear in `cur_base` one cycle later, or it drops `run_req` and presents a different address, which must not be taken while `busy` falls. A restart on the very next clock then has to pick that pending address up. A behavioural model follows every cycle, including frames whose vertical sync is counted in clocks and is longer than one line.

// File: rtl/tg_pkg.sv
package tg_pkg;
   typedef enum logic {
      TG_IDLE = 1'b0,
      TG_RUN  = 1'b1
   } tg_run_e;

   localparam int unsigned TG_NSIG   = 3;
   localparam int unsigned TG_SIG_HS = 0;
   localparam int unsigned TG_SIG_VS = 1;
   localparam int unsigned TG_SIG_DE = 2;
endpackage

// File: rtl/tg_axis.sv
// One timing axis: a wrapping counter plus a window compare and a
// position output that holds outside the window.
module tg_axis #(
   parameter int unsigned CW = 18,
   parameter int unsigned WW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          act,
   input  logic [CW-1:0] period,
   input  logic [WW-1:0] wait_c,
   input  logic [CW-1:0] span,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          in_win,
   output logic [CW-1:0] pos
);
   if (WW > CW) begin : g_bad_wait_width
      $error("tg_axis: wait width exceeds counter width");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] pos_q;
   logic [CW:0]   lo;
   logic [CW:0]   hi;

   assign lo     = (CW+1)'(wait_c);
   assign hi     = lo + (CW+1)'(span);
   assign cnt    = cnt_q;
   assign last   = (cnt_q == period - 1'b1);
   assign in_win = act && ({1'b0, cnt_q} >= lo) && ({1'b0, cnt_q} < hi);
   assign pos    = in_win ? (cnt_q - lo[CW-1:0]) : pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pos_q <= '0;
      end else begin
         if (clr)       cnt_q <= '0;
         else if (step) cnt_q <= last ? '0 : cnt_q + 1'b1;
         pos_q <= pos;
      end
   end

   p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act && period != '0) |-> (cnt_q < period));
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !clr) |=> (cnt_q == '0));
   p_pos_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> (in_win || $stable(pos)));
endmodule

// File: rtl/tg_vwidth.sv
// Vertical sync width tracker: loaded at frame start, counts down on ticks.
module tg_vwidth #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         tick,
   input  logic [W-1:0] width,
   output logic         on
);
   logic [W-1:0] rem_q;

   assign on = (rem_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rem_q <= '0;
      else if (load)         rem_q <= width;
      else if (on && tick)   rem_q <= rem_q - 1'b1;
   end

   p_vs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rem_q == $past(width)));
endmodule

// File: rtl/tg_polarity.sv
// Pin level stage: active level chosen per signal, inactive when not enabled.
module tg_polarity #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] act,
   input  logic [N-1:0] en,
   input  logic [N-1:0] pol,
   output logic [N-1:0] pin
);
   for (genvar i = 0; i < N; i++) begin : g_sig
      assign pin[i] = (act[i] && en[i]) ? pol[i] : ~pol[i];
   end
endmodule

// File: rtl/dotclk_timing_gen.sv
module dotclk_timing_gen
   import tg_pkg::*;
#(
   parameter int unsigned HW      = 18,
   parameter int unsigned VW      = 16,
   parameter int unsigned HWAIT_W = 12,
   parameter int unsigned HSW_W   = 14,
   parameter int unsigned VSW_W   = 18,
   parameter int unsigned AW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_req,
   input  logic               sync_en,
   input  logic               vsync_unit_lines,
   input  logic [HW-1:0]      line_period,
   input  logic [HSW_W-1:0]   hsync_width,
   input  logic [HWAIT_W-1:0] h_wait,
   input  logic [HW-1:0]      h_active,
   input  logic [VW-1:0]      frame_lines,
   input  logic [VSW_W-1:0]   vsync_width,
   input  logic [VW-1:0]      v_wait,
   input  logic [VW-1:0]      v_active,
   input  logic               hs_high,
   input  logic               vs_high,
   input  logic               de_high,
   input  logic               fall_edge,
   input  logic [AW-1:0]      next_base,
   output logic               hsync,
   output logic               vsync,
   output logic               de,
   output logic               pix_req,
   output logic [HW-1:0]      xpos,
   output logic [VW-1:0]      ypos,
   output logic [AW-1:0]      cur_base,
   output logic               busy,
   output logic               sample_falling
);
   if (HSW_W > HW) begin : g_bad_hsw
      $error("dotclk_timing_gen: hsync width field wider than line counter");
   end
   if (HWAIT_W > HW) begin : g_bad_hwait
      $error("dotclk_timing_gen: horizontal wait field wider than line counter");
   end

   tg_run_e       run_q;
   logic          running, start, frame_end, frame_start;
   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          h_last, v_last, h_in, v_in;
   logic          hs_act, vs_on, vs_tick;
   logic [AW-1:0] base_q;
   logic [TG_NSIG-1:0] sig_act, sig_en, sig_pol, sig_pin;

   assign running     = (run_q == TG_RUN);
   assign start       = !running && run_req;
   assign frame_end   = running && h_last && v_last;
   assign frame_start = start || (frame_end && run_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= TG_IDLE;
      else if (start)                  run_q <= TG_RUN;
      else if (frame_end && !run_req)  run_q <= TG_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           base_q <= '0;
      else if (frame_start) base_q <= next_base;
   end

   tg_axis #(.CW(HW), .WW(HWAIT_W)) u_hax (
      .clk(clk), .rst_n(rst_n), .clr(start), .step(running), .act(running),
      .period(line_period), .wait_c(h_wait), .span(h_active),
      .cnt(hcnt), .last(h_last), .in_win(h_in), .pos(xpos)
   );

   tg_axis #(.CW(VW), .WW(VW)) u_vax (
      .clk(clk), .rst_n(rst_n), .clr(start), .step(running && h_last), .act(running),
      .period(frame_lines), .wait_c(v_wait), .span(v_active),
      .cnt(vcnt), .last(v_last), .in_win(v_in), .pos(ypos)
   );

   assign vs_tick = vsync_unit_lines ? (running && h_last) : running;

   tg_vwidth #(.W(VSW_W)) u_vw (
      .clk(clk), .rst_n(rst_n), .load(frame_start), .tick(vs_tick),
      .width(vsync_width), .on(vs_on)
   );

   assign hs_act  = running && (hcnt < HW'(hsync_width));
   assign pix_req = h_in && v_in;

   assign sig_act[TG_SIG_HS] = hs_act;
   assign sig_act[TG_SIG_VS] = running && vs_on;
   assign sig_act[TG_SIG_DE] = pix_req;
   assign sig_en[TG_SIG_HS]  = sync_en;
   assign sig_en[TG_SIG_VS]  = sync_en;
   assign sig_en[TG_SIG_DE]  = 1'b1;
   assign sig_pol[TG_SIG_HS] = hs_high;
   assign sig_pol[TG_SIG_VS] = vs_high;
   assign sig_pol[TG_SIG_DE] = de_high;

   tg_polarity #(.N(TG_NSIG)) u_pol (
      .act(sig_act), .en(sig_en), .pol(sig_pol), .pin(sig_pin)
   );

   assign hsync          = sig_pin[TG_SIG_HS];
   assign vsync          = sig_pin[TG_SIG_VS];
   assign de             = sig_pin[TG_SIG_DE];
   assign cur_base       = base_q;
   assign busy           = running;
   assign sample_falling = fall_edge;

   p_start_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && hcnt == '0 && vcnt == '0));
   p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !run_req && !frame_end) |=> busy);
   p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(cur_base));
   p_sync_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |-> (hsync == !hs_high && vsync == !vs_high));
endmodule

// File: tb/dotclk_timing_gen_tb.sv
`timescale 1ns/1ps
module dotclk_timing_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_req = 0, sync_en = 1, vsync_unit_lines = 1;
   logic [17:0] line_period = 18'd10;
   logic [13:0] hsync_width = 14'd2;
   logic [11:0] h_wait = 12'd3;
   logic [17:0] h_active = 18'd5;
   logic [15:0] frame_lines = 16'd8;
   logic [17:0] vsync_width = 18'd2;
   logic [15:0] v_wait = 16'd3;
   logic [15:0] v_active = 16'd4;
   logic hs_high = 1, vs_high = 1, de_high = 1, fall_edge = 0;
   logic [31:0] next_base = 32'h0000_0A00;
   logic hsync, vsync, de, pix_req, busy, sample_falling;
   logic [17:0] xpos;
   logic [15:0] ypos;
   logic [31:0] cur_base;

   int n_cmp = 0, n_bad = 0;
   bit chk_on = 0, done = 0;

   // reference model state
   int mh = 0, mv = 0, mvs = 0, mxq = 0, myq = 0;
   bit mrun = 0;
   logic [31:0] mbase = '0;

   always #2.5 clk = ~clk;

   dotclk_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .sync_en(sync_en),
      .vsync_unit_lines(vsync_unit_lines), .line_period(line_period),
      .hsync_width(hsync_width), .h_wait(h_wait), .h_active(h_active),
      .frame_lines(frame_lines), .vsync_width(vsync_width), .v_wait(v_wait),
      .v_active(v_active), .hs_high(hs_high), .vs_high(vs_high), .de_high(de_high),
      .fall_edge(fall_edge), .next_base(next_base), .hsync(hsync), .vsync(vsync),
      .de(de), .pix_req(pix_req), .xpos(xpos), .ypos(ypos), .cur_base(cur_base),
      .busy(busy), .sample_falling(sample_falling)
   );

   task automatic cmp(input string req, input string nm, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
      end
   endtask

   function automatic bit in_h();
      return mrun && mh >= int'(h_wait) && mh < int'(h_wait) + int'(h_active);
   endfunction
   function automatic bit in_v();
      return mrun && mv >= int'(v_wait) && mv < int'(v_wait) + int'(v_active);
   endfunction

   // model update on the active edge (inputs were driven 1 ns after the previous edge)
   always @(posedge clk) begin
      bit hin, vin, hl, vl, st, fe, fs, tk;
      int ex, ey;
      if (!rst_n) begin
         mh = 0; mv = 0; mvs = 0; mxq = 0; myq = 0; mrun = 0; mbase = '0;
      end else begin
         hin = in_h(); vin = in_v();
         ex = hin ? mh - int'(h_wait) : mxq;
         ey = vin ? mv - int'(v_wait) : myq;
         hl = mrun && (mh == int'(line_period) - 1);
         vl = (mv == int'(frame_lines) - 1);
         st = !mrun && run_req;
         fe = hl && vl;
         fs = st || (fe && run_req);
         tk = vsync_unit_lines ? hl : mrun;
         mxq = ex; myq = ey;
         if (fs) mvs = int'(vsync_width);
         else if (mvs != 0 && tk) mvs = mvs - 1;
         if (fs) mbase = next_base;
         if (st) begin mh = 0; mv = 0; end
         else if (mrun) begin
            if (hl) begin mh = 0; mv = vl ? 0 : mv + 1; end
            else mh = mh + 1;
         end
         if (st) mrun = 1;
         else if (fe && !run_req) mrun = 0;
      end
   end

   // per-cycle comparison, half a period after the edge
   always @(negedge clk) begin
      bit hin, vin, eh, ev, ep;
      if (chk_on && rst_n) begin
         hin = in_h(); vin = in_v();
         eh = (sync_en && mrun && mh < int'(hsync_width)) ? hs_high : !hs_high;
         ev = (sync_en && mrun && mvs != 0) ? vs_high : !vs_high;
         ep = hin && vin;
         cmp(sync_en ? "R3" : "R8", "hsync", hsync, eh);
         cmp(sync_en ? "R4" : "R8", "vsync", vsync, ev);
         cmp("R5", "pix_req", pix_req, ep);
         cmp("R7", "de", de, ep ? de_high : !de_high);
         cmp("R6", "xpos", xpos, hin ? mh - int'(h_wait) : mxq);
         cmp("R6", "ypos", ypos, vin ? mv - int'(v_wait) : myq);
         cmp("R9", "cur_base", cur_base, mbase);
         cmp("R10", "busy", busy, mrun);
         cmp("R11", "sample_falling", sample_falling, fall_edge);
      end
   end

   task automatic step_drive(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic to_last_pixel();
      // returns 1 ns after the edge that put the model on the final pixel of a frame
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #1;
         if (mrun && mh == int'(line_period) - 1 && mv == int'(frame_lines) - 1) break;
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #1;
         if (!mrun) break;
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      step_drive(3);
      @(negedge clk);
      // R1: reset state
      cmp("R1", "busy", busy, 0);
      cmp("R1", "pix_req", pix_req, 0);
      cmp("R1", "hsync", hsync, 0);
      cmp("R1", "vsync", vsync, 0);
      cmp("R1", "de", de, 0);
      cmp("R1", "cur_base", cur_base, 0);
      cmp("R1", "xpos", xpos, 0);
      step_drive(1);
      rst_n = 1; chk_on = 1;
      step_drive(2);

      // R2: start from idle
      run_req = 1;
      @(posedge clk); @(negedge clk);
      cmp("R2", "busy", busy, 1);
      cmp("R2", "hsync", hsync, 1);
      cmp("R2", "vsync", vsync, 1);
      cmp("R2", "cur_base", cur_base, 32'h0A00);
      step_drive(0);

      // R9: change mid-frame, not taken yet
      step_drive(37);
      next_base = 32'h0000_0B00;
      @(negedge clk);
      cmp("R9", "cur_base mid-frame", cur_base, 32'h0A00);
      step_drive(200);

      // R9 corner: address change on the final pixel while running
      to_last_pixel();
      next_base = 32'h0000_0C00;
      @(posedge clk); @(negedge clk);
      cmp("R9", "cur_base at wrap", cur_base, 32'h0C00);
      step_drive(50);

      // R10: stop mid-frame, drain
      run_req = 0;
      @(negedge clk);
      cmp("R10", "busy draining", busy, 1);
      wait_idle();
      @(negedge clk);
      cmp("R10", "busy after drain", busy, 0);
      cmp("R10", "pix_req idle", pix_req, 0);

      // R7/R4: inverted polarities, vsync counted in clocks, longer than a line
      hs_high = 0; vs_high = 0; de_high = 0;
      vsync_unit_lines = 0; vsync_width = 18'd13;
      fall_edge = 1;
      line_period = 18'd12; hsync_width = 14'd3; h_wait = 12'd4; h_active = 18'd6;
      frame_lines = 16'd9; v_wait = 16'd2; v_active = 16'd5;
      step_drive(2);
      run_req = 1;
      step_drive(230);

      // R8: sync disabled while running
      sync_en = 0;
      step_drive(120);
      @(negedge clk);
      cmp("R8", "hsync gated", hsync, 1);
      cmp("R8", "vsync gated", vsync, 1);
      step_drive(0);
      sync_en = 1;

      // corner: stop request and address change on the same final pixel
      to_last_pixel();
      run_req = 0;
      next_base = 32'h0000_0D00;
      @(posedge clk); @(negedge clk);
      cmp("R10", "busy stop at frame end", busy, 0);
      cmp("R9", "cur_base not taken on stop", cur_base, 32'h0C00);
      step_drive(0);
      // restart on the next clock picks up the pending address
      run_req = 1;
      @(posedge clk); @(negedge clk);
      cmp("R2", "busy restart", busy, 1);
      cmp("R9", "cur_base on restart", cur_base, 32'h0D00);
      step_drive(0);

      // back to lines mode, active-high, a few frames
      hs_high = 1; vs_high = 1; de_high = 1; fall_edge = 0;
      step_drive(1);
      run_req = 0;
      wait_idle();
      vsync_unit_lines = 1; vsync_width = 18'd3;
      step_drive(1);
      run_req = 1;
      step_drive(300);
      run_req = 0;
      wait_idle();
      step_drive(10);

      done = 1;
      summary();
      $finish;
   end
endmodule